// File: doc/BRIEF.md
# Timing Reference Selection Controller

This controller sits beside the digital PLL of a telecom clock synchronizer. It chooses which of two timing references, primary or secondary, the PLL follows. It also decides whether the PLL tracks that reference, holds its last frequency word, or runs free from the local master clock. Its inputs are a validity flag for each reference (from an impairment monitor), a mode pin, a three-bit manual state request, and a guard-time flag. The guard-time flag reports that a recovered reference has stayed good for long enough.

In manual mode the request code picks the state directly. In automatic mode the controller fails over by itself. When the primary is lost, it holds. It returns to the primary once the primary is requalified. If the primary stays bad past a holdover timeout while the secondary is usable, it moves to the secondary. A swap of references always passes through a holdover cycle, so the PLL never jumps phase. The PLL receives a one-cycle freeze pulse when the controller enters holdover and a one-cycle re-acquire pulse when it enters tracking. All outputs are registered, so each reflects the decision made at the previous clock edge.

Top module: `tref_select_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high) puts the block in free-run: `state_code` 100, `ref_sel` 0 (primary), and both pulses low.
- R2: `state_code` reads 000 for primary tracking, 001 for secondary tracking, 010 for primary holdover, 011 for secondary holdover and 100 for free-run. Exactly one of `pll_track`, `pll_hold` and `pll_free` is high: track for 00x, hold for 01x, free for 1xx. In free-run `ref_sel` keeps its last value.
- R3: A tracking state is entered only if the target reference's valid flag and `guard_ok` were both high at the deciding edge. Otherwise the request is ignored and the state stays unchanged.
- R4: In manual mode (`auto_mode` 0), `man_code` 010 and 011 select primary and secondary holdover, and any 1xx code selects free-run, on the next edge, whatever the validity flags.
- R5: In manual mode, a request to track the other reference while already tracking first moves to holdover on the current reference for at least one cycle, and only then to tracking on the new one.
- R6: In automatic mode, primary tracking with `pri_ok` low moves to primary holdover on the next edge.
- R7: In automatic mode, primary holdover returns to primary tracking only when `pri_ok` and `guard_ok` are both high. If the primary turns bad again, or `guard_ok` is low, it keeps holding.
- R8: In automatic mode, after `HOLD_TMO`+1 cycles in primary holdover with `pri_ok` still low, the block moves to secondary tracking if `sec_ok` and `guard_ok` are high.
- R9: In automatic mode on the secondary, loss of `sec_ok` or a requalified primary moves to secondary holdover. From there a requalified primary leads to primary tracking, and a requalified secondary leads back to secondary tracking.
- R10: `freeze_pulse` is high for exactly the first cycle of any holdover state entered from a non-holdover state.
- R11: `reacq_pulse` is high for exactly the first cycle of any tracking state.
- R12: `ref_sel` changes only together with a change of `state_code`, and never between two consecutive tracking cycles.
- R13: In automatic mode, free-run moves to primary tracking once the primary is requalified. A manually selected holdover carries on under the automatic rules for its reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| pri_ok | input | 1 | Primary reference reported valid |
| sec_ok | input | 1 | Secondary reference reported valid |
| auto_mode | input | 1 | 1 selects automatic failover, 0 manual |
| man_code | input | 3 | Requested state code in manual mode |
| guard_ok | input | 1 | Recovered reference has been good for the guard time |
| state_code | output | 3 | Current state code |
| pll_track | output | 1 | PLL tracks the selected reference |
| pll_hold | output | 1 | PLL holds its stored frequency |
| pll_free | output | 1 | PLL runs from the master clock only |
| ref_sel | output | 1 | 0 primary, 1 secondary |
| freeze_pulse | output | 1 | One-cycle pulse on entering holdover |
| reacq_pulse | output | 1 | One-cycle pulse on entering tracking |

## Verification
The assertions check properties that must hold on every cycle. Exactly one PLL control output is active, and it agrees with the state code. Tracking never begins without a valid, guard-qualified reference. The reference never changes while tracking continues, and the pulses line up with state entries. Primary loss in automatic mode must lead to holdover. Only the directed scenarios can show the longer sequences: the holdover timeout count before failover, the revert from secondary to primary through holdover, and a qualification aborted when the primary fails again.

// File: rtl/tref_pkg.sv
package tref_pkg;

    typedef enum logic [2:0] {
        ST_PNRM = 3'd0,
        ST_SNRM = 3'd1,
        ST_PHLD = 3'd2,
        ST_SHLD = 3'd3,
        ST_APHL = 3'd4,
        ST_ASHL = 3'd5,
        ST_FREE = 3'd6
    } tref_state_e;

    typedef struct packed {
        tref_state_e st;
        logic        ref_sel;
        logic        frz;
        logic        rcq;
    } tref_regs_t;

    function automatic logic is_norm(tref_state_e s);
        return (s == ST_PNRM) || (s == ST_SNRM);
    endfunction

    function automatic logic is_hold(tref_state_e s);
        return (s == ST_PHLD) || (s == ST_SHLD) || (s == ST_APHL) || (s == ST_ASHL);
    endfunction

    function automatic logic ref_bound(tref_state_e s);
        return s != ST_FREE;
    endfunction

    function automatic logic ref_of(tref_state_e s);
        return (s == ST_SNRM) || (s == ST_SHLD) || (s == ST_ASHL);
    endfunction

endpackage

// File: rtl/tref_hold_timer.sv
module tref_hold_timer #(
    parameter int HOLD_TMO = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic hit
);
    localparam int CNT_W = $clog2(HOLD_TMO + 1);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(HOLD_TMO);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (run) begin
            cnt_d = (cnt_q == LIM) ? cnt_q : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign hit = run && (cnt_q == LIM);
endmodule

// File: rtl/tref_next.sv
module tref_next
    import tref_pkg::*;
(
    input  tref_state_e cur,
    input  logic        auto_mode,
    input  logic [2:0]  man_code,
    input  logic        pri_ok,
    input  logic        sec_ok,
    input  logic        guard_ok,
    input  logic        tmo_hit,
    output tref_state_e nxt
);
    logic pri_q, sec_q;

    always_comb begin
        pri_q = pri_ok && guard_ok;
        sec_q = sec_ok && guard_ok;
        nxt   = cur;
        if (!auto_mode) begin
            casez (man_code)
                3'b000: begin
                    if (cur == ST_SNRM) nxt = ST_SHLD;
                    else if (pri_q)     nxt = ST_PNRM;
                end
                3'b001: begin
                    if (cur == ST_PNRM) nxt = ST_PHLD;
                    else if (sec_q)     nxt = ST_SNRM;
                end
                3'b010:  nxt = ST_PHLD;
                3'b011:  nxt = ST_SHLD;
                default: nxt = ST_FREE;
            endcase
        end else begin
            case (cur)
                ST_PNRM: if (!pri_ok) nxt = ST_APHL;
                ST_SNRM: if (!sec_ok || pri_q) nxt = ST_ASHL;
                ST_PHLD, ST_APHL: begin
                    if (pri_q)                          nxt = ST_PNRM;
                    else if (tmo_hit && !pri_ok && sec_q) nxt = ST_SNRM;
                    else                                nxt = ST_APHL;
                end
                ST_SHLD, ST_ASHL: begin
                    if (pri_q)      nxt = ST_PNRM;
                    else if (sec_q) nxt = ST_SNRM;
                    else            nxt = ST_ASHL;
                end
                default: if (pri_q) nxt = ST_PNRM;
            endcase
        end
    end
endmodule

// File: rtl/tref_out_decode.sv
module tref_out_decode
    import tref_pkg::*;
(
    input  tref_state_e st,
    output logic [2:0]  code,
    output logic        track,
    output logic        hold,
    output logic        free
);
    always_comb begin
        case (st)
            ST_PNRM:          code = 3'b000;
            ST_SNRM:          code = 3'b001;
            ST_PHLD, ST_APHL: code = 3'b010;
            ST_SHLD, ST_ASHL: code = 3'b011;
            default:          code = 3'b100;
        endcase
        track = is_norm(st);
        hold  = is_hold(st);
        free  = (st == ST_FREE);
    end
endmodule

// File: rtl/tref_select_ctrl.sv
module tref_select_ctrl
    import tref_pkg::*;
#(
    parameter int HOLD_TMO = 1024
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pri_ok,
    input  logic       sec_ok,
    input  logic       auto_mode,
    input  logic [2:0] man_code,
    input  logic       guard_ok,
    output logic [2:0] state_code,
    output logic       pll_track,
    output logic       pll_hold,
    output logic       pll_free,
    output logic       ref_sel,
    output logic       freeze_pulse,
    output logic       reacq_pulse
);
    tref_regs_t  r_d, r_q;
    tref_state_e st_nxt;
    logic        tmo_hit;

    tref_hold_timer #(.HOLD_TMO(HOLD_TMO)) timer_i (
        .clk (clk),
        .rst (rst),
        .run (r_q.st == ST_APHL),
        .hit (tmo_hit)
    );

    tref_next next_i (
        .cur       (r_q.st),
        .auto_mode (auto_mode),
        .man_code  (man_code),
        .pri_ok    (pri_ok),
        .sec_ok    (sec_ok),
        .guard_ok  (guard_ok),
        .tmo_hit   (tmo_hit),
        .nxt       (st_nxt)
    );

    always_comb begin
        r_d.st      = st_nxt;
        r_d.ref_sel = ref_bound(st_nxt) ? ref_of(st_nxt) : r_q.ref_sel;
        r_d.frz     = is_hold(st_nxt) && !is_hold(r_q.st);
        r_d.rcq     = is_norm(st_nxt) && !is_norm(r_q.st);
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '{st: ST_FREE, ref_sel: 1'b0, frz: 1'b0, rcq: 1'b0};
        else     r_q <= r_d;
    end

    tref_out_decode dec_i (
        .st    (r_q.st),
        .code  (state_code),
        .track (pll_track),
        .hold  (pll_hold),
        .free  (pll_free)
    );

    assign ref_sel      = r_q.ref_sel;
    assign freeze_pulse = r_q.frz;
    assign reacq_pulse  = r_q.rcq;
endmodule

// File: rtl/tref_select_ctrl_chk.sv
module tref_select_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       pri_ok,
    input logic       sec_ok,
    input logic       auto_mode,
    input logic       guard_ok,
    input logic [2:0] state_code,
    input logic       pll_track,
    input logic       pll_hold,
    input logic       pll_free,
    input logic       ref_sel,
    input logic       freeze_pulse,
    input logic       reacq_pulse
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (state_code == 3'b100 && !ref_sel && !freeze_pulse && !reacq_pulse));

    // R2
    ctrl_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot({pll_track, pll_hold, pll_free}) && (pll_free == state_code[2])
        && (pll_hold == (state_code[2:1] == 2'b01)));

    // R3
    norm_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pll_track) |-> ($past(guard_ok) && (ref_sel ? $past(sec_ok) : $past(pri_ok))));

    // R6
    pri_loss_chk: assert property (@(posedge clk) disable iff (rst)
        (auto_mode && pll_track && !ref_sel && !pri_ok) |=> (pll_hold && !ref_sel));

    // R10
    freeze_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        freeze_pulse == (pll_hold && !$past(pll_hold)));

    // R11
    reacq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        reacq_pulse == (pll_track && !$past(pll_track)));

    // R12
    ref_change_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(ref_sel) |-> !$stable(state_code));

    // R12
    ref_track_chk: assert property (@(posedge clk) disable iff (rst)
        (pll_track && $past(pll_track)) |-> $stable(ref_sel));
endmodule

bind tref_select_ctrl tref_select_ctrl_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .pri_ok       (pri_ok),
    .sec_ok       (sec_ok),
    .auto_mode    (auto_mode),
    .guard_ok     (guard_ok),
    .state_code   (state_code),
    .pll_track    (pll_track),
    .pll_hold     (pll_hold),
    .pll_free     (pll_free),
    .ref_sel      (ref_sel),
    .freeze_pulse (freeze_pulse),
    .reacq_pulse  (reacq_pulse)
);

// File: tb/tref_select_ctrl_tb_top.sv
module tref_select_ctrl_tb_top;
    localparam int TMO = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pri_ok = 1'b0, sec_ok = 1'b0, auto_mode = 1'b0, guard_ok = 1'b0;
    logic [2:0] man_code = 3'b100;
    logic [2:0] state_code;
    logic       pll_track, pll_hold, pll_free, ref_sel, freeze_pulse, reacq_pulse;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    tref_select_ctrl #(.HOLD_TMO(TMO)) dut_i (
        .clk(clk), .rst(rst), .pri_ok(pri_ok), .sec_ok(sec_ok),
        .auto_mode(auto_mode), .man_code(man_code), .guard_ok(guard_ok),
        .state_code(state_code), .pll_track(pll_track), .pll_hold(pll_hold),
        .pll_free(pll_free), .ref_sel(ref_sel),
        .freeze_pulse(freeze_pulse), .reacq_pulse(reacq_pulse)
    );

    // expected vector {code, ref, track, hold, free, freeze, reacq} from R2
    function automatic logic [8:0] ev(logic [2:0] code, logic rs, logic frz, logic rcq);
        return {code, rs, code[2:1] == 2'b00, code[2:1] == 2'b01, code[2], frz, rcq};
    endfunction

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [8:0] exp);
        logic [8:0] got;
        got = {state_code, ref_sel, pll_track, pll_hold, pll_free, freeze_pulse, reacq_pulse};
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%b exp=%b (code,ref,trk,hld,free,frz,rcq)", req, got, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; step(); step();
        chk("R1 reset", ev(3'b100, 0, 0, 0));
        rst = 1'b0;
    endtask

    task automatic t_manual_codes();
        auto_mode = 0; pri_ok = 1; sec_ok = 1; guard_ok = 1;
        man_code = 3'b000; step(); chk("R11 manual primary track", ev(3'b000, 0, 0, 1));
        step(); chk("R11 pulse one cycle", ev(3'b000, 0, 0, 0));
        man_code = 3'b010; step(); chk("R4 R10 primary hold", ev(3'b010, 0, 1, 0));
        step(); chk("R10 freeze one cycle", ev(3'b010, 0, 0, 0));
        man_code = 3'b011; step(); chk("R4 R12 hold to hold", ev(3'b011, 1, 0, 0));
        man_code = 3'b101; step(); chk("R2 R4 free keeps ref", ev(3'b100, 1, 0, 0));
    endtask

    task automatic t_manual_blocked();
        sec_ok = 0; man_code = 3'b001; step(); chk("R3 invalid ref blocked", ev(3'b100, 1, 0, 0));
        sec_ok = 1; guard_ok = 0; step(); chk("R3 no guard blocked", ev(3'b100, 1, 0, 0));
        guard_ok = 1; step(); chk("R3 qualified entry", ev(3'b001, 1, 0, 1));
    endtask

    task automatic t_manual_cross();
        man_code = 3'b000; step(); chk("R5 via secondary hold", ev(3'b011, 1, 1, 0));
        step(); chk("R5 R12 then primary", ev(3'b000, 0, 0, 1));
    endtask

    task automatic t_auto_loss_abort();
        auto_mode = 1; sec_ok = 0; pri_ok = 0; guard_ok = 1;
        step(); chk("R6 primary loss", ev(3'b010, 0, 1, 0));
        pri_ok = 1; guard_ok = 0; step(); chk("R7 unqualified stays", ev(3'b010, 0, 0, 0));
        pri_ok = 0; step(); chk("R7 guard abort", ev(3'b010, 0, 0, 0));
        pri_ok = 1; guard_ok = 1; step(); chk("R7 requalified return", ev(3'b000, 0, 0, 1));
    endtask

    task automatic t_failover();
        pri_ok = 0; sec_ok = 1; guard_ok = 1;
        step(); chk("R8 hold first", ev(3'b010, 0, 1, 0));
        repeat (TMO) step();
        chk("R8 not before timeout", ev(3'b010, 0, 0, 0));
        step(); chk("R8 to secondary", ev(3'b001, 1, 0, 1));
    endtask

    task automatic t_revert();
        pri_ok = 1; guard_ok = 0; step(); chk("R9 stay on secondary", ev(3'b001, 1, 0, 0));
        guard_ok = 1; step(); chk("R9 revert via hold", ev(3'b011, 1, 1, 0));
        step(); chk("R9 R12 back to primary", ev(3'b000, 0, 0, 1));
    endtask

    task automatic t_sec_loss();
        t_failover();
        sec_ok = 0; step(); chk("R9 secondary loss", ev(3'b011, 1, 1, 0));
        sec_ok = 1; step(); chk("R9 secondary return", ev(3'b001, 1, 0, 1));
    endtask

    task automatic t_auto_from_manual();
        auto_mode = 0; man_code = 3'b100; step(); chk("R4 manual free", ev(3'b100, 1, 0, 0));
        auto_mode = 1; pri_ok = 0; step(); chk("R13 free waits", ev(3'b100, 1, 0, 0));
        pri_ok = 1; guard_ok = 1; step(); chk("R13 free to primary", ev(3'b000, 0, 0, 1));
        auto_mode = 0; man_code = 3'b011; step(); chk("R4 manual sec hold", ev(3'b011, 1, 1, 0));
        auto_mode = 1; pri_ok = 0; sec_ok = 1; step(); chk("R13 hold to secondary", ev(3'b001, 1, 0, 1));
    endtask

    initial begin
        t_reset();
        t_manual_codes();
        t_manual_blocked();
        t_manual_cross();
        t_auto_loss_abort();
        t_failover();
        t_revert();
        t_sec_loss();
        t_auto_from_manual();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule